// File: doc/BRIEF.md
# Streaming Transmit Packet Ingress Checker

This block sits between user logic and a transmit MAC core. User logic pushes packets over a 128-bit streaming bus with valid, start, end, empty and error sidebands. The block applies a ready rule with a fixed latency of 0 or 3 cycles, checks that the packets are framed correctly and forwards the beats it keeps downstream, one cycle later. At the close of every packet it issues a one-cycle status record that holds the packet's byte length and four error flags.

The bus carries bytes from the most significant end down: on a start beat, the first byte of the packet is in bits [127:120]. A packet that starts and ends on the same beat is dropped. Beats that arrive outside a packet are discarded and reported. A start that arrives while a packet is still open closes the older packet as truncated. When preamble checking is enabled, the marker byte presented with each start beat must equal 8'hFB.

Top module: `tx_ingress_check`

## Requirements
- R1: With READY_LAT=0, `in_ready` equals `ds_ready`, and a beat is accepted only in a cycle where `in_valid` and `in_ready` are both high.
- R2: With READY_LAT=3, a beat is accepted only when `in_valid` is high exactly 3 cycles after a cycle in which `in_ready` was high. A valid beat at any other time is ignored.
- R3: Each accepted beat that belongs to a packet appears on `out_valid`/`out_data` in the next cycle, with its data unchanged and its start and end flags carried along.
- R4: An accepted beat with both start and end set is neither forwarded nor reported in a status record.
- R5: `in_empty` has an effect only on an end beat. `out_empty` carries it on the forwarded end beat and is 0 on every other forwarded beat.
- R6: One cycle after an accepted end beat of an open packet, `sts_valid` pulses high with `sts_len` = 16 × beats − empty.
- R7: The status flags are `sts_flags[3]` = user error, `[2]` = preamble error, `[1]` = truncation and `[0]` = orphan data. Bit 3 copies `in_err` as sampled on the end beat.
- R8: With PRE_CHECK=1, `sts_flags[2]` is set when `in_pre_tag` on the packet's start beat is not 8'hFB.
- R9: A start beat accepted while a packet is open produces a status record in the next cycle with bit 1 set and `sts_len` = 16 × the beats received so far. If the new start beat is not also an end beat, it opens a new packet that is forwarded.
- R10: Beats accepted without a start while no packet is open are dropped. They set an orphan flag that is reported in bit 0 of the next status record and then cleared.
- R11: A status record without the truncation flag always shows a length of at least 17 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ds_ready | input | 1 | Downstream can take a beat |
| in_ready | output | 1 | Ready toward user logic |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Start-of-packet beat |
| in_eop | input | 1 | End-of-packet beat |
| in_empty | input | 4 | Invalid bytes in the end beat |
| in_err | input | 1 | User error, sampled on the end beat |
| in_pre_tag | input | 8 | Top byte of the preamble, sampled on the start beat |
| in_data | input | 128 | Beat data, first byte in [127:120] |
| out_valid | output | 1 | Forwarded beat valid |
| out_sop | output | 1 | Forwarded start |
| out_eop | output | 1 | Forwarded end |
| out_empty | output | 4 | Forwarded empty count |
| out_data | output | 128 | Forwarded data |
| sts_valid | output | 1 | Status record valid, one cycle |
| sts_len | output | 16 | Packet byte length |
| sts_flags | output | 4 | {user, preamble, truncation, orphan} |

## Verification
On every cycle the assertions check the following: no beat is forwarded unless a valid beat came in the cycle before; single-beat packets and orphan beats never reach the output; `out_empty` is zero away from end beats; a start inside an open packet raises the truncation record; and records without truncation never fall below the minimum length. The exact byte lengths and flag combinations, the sticky orphan flag carried into a later record, and the ready rule with latency 3 can only be shown by the bench's scenarios, which compare against a cycle model.

// File: rtl/tx_ingress_check.sv
module tx_ingress_check #(
  parameter int READY_LAT = 0,
  parameter bit PRE_CHECK = 1'b1,
  parameter int DW = 128,
  parameter int EW = 4,
  parameter int LW = 16,
  parameter logic [7:0] PRE_MARK = 8'hFB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ds_ready,
  output logic          in_ready,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [EW-1:0] in_empty,
  input  logic          in_err,
  input  logic [7:0]    in_pre_tag,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sop,
  output logic          out_eop,
  output logic [EW-1:0] out_empty,
  output logic [DW-1:0] out_data,
  output logic          sts_valid,
  output logic [LW-1:0] sts_len,
  output logic [3:0]    sts_flags
);
  localparam int BPB = DW / 8;

  logic take, in_pkt, pre_q, orph_q;
  logic [LW-1:0] len_q;

  assign in_ready = ds_ready;

  generate
    if (READY_LAT == 0) begin : g_lat0
      assign take = in_valid & in_ready;
    end else begin : g_latn
      logic [READY_LAT-1:0] rdy_hist;
      always_ff @(posedge clk)
        if (!rst_n) rdy_hist <= '0;
        else        rdy_hist <= {rdy_hist[READY_LAT-2:0], in_ready};
      assign take = in_valid & rdy_hist[READY_LAT-1];
    end
  endgenerate

  wire solo    = take & in_sop & in_eop;
  wire starts  = take & in_sop & ~in_eop;
  wire cont    = take & ~in_sop & in_pkt;
  wire orphan  = take & ~in_sop & ~in_pkt;
  wire closes  = cont & in_eop;
  wire trunc   = take & in_sop & in_pkt;
  wire pre_bad = PRE_CHECK && (in_pre_tag != PRE_MARK);
  wire [LW-1:0] len_next = len_q + LW'(BPB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      pre_q     <= 1'b0;
      orph_q    <= 1'b0;
      len_q     <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_empty <= '0;
      out_data  <= '0;
      sts_valid <= 1'b0;
      sts_len   <= '0;
      sts_flags <= '0;
    end else begin
      out_valid <= starts | cont;
      out_sop   <= starts;
      out_eop   <= closes;
      out_empty <= closes ? in_empty : '0;
      if (starts | cont) out_data <= in_data;

      sts_valid <= closes | trunc;
      if (closes) begin
        sts_len   <= len_next - LW'(in_empty);
        sts_flags <= {in_err, pre_q, 1'b0, orph_q};
      end else if (trunc) begin
        sts_len   <= len_q;
        sts_flags <= {1'b0, pre_q, 1'b1, orph_q};
      end

      if (orphan)              orph_q <= 1'b1;
      else if (closes | trunc) orph_q <= 1'b0;

      if (starts)              in_pkt <= 1'b1;
      else if (closes | solo)  in_pkt <= 1'b0;

      if (starts) begin
        len_q <= LW'(BPB);
        pre_q <= pre_bad;
      end else if (cont) begin
        len_q <= len_next;
      end
    end
  end
endmodule

module tx_ingress_check_sva #(
  parameter int LW = 16,
  parameter int EW = 4,
  parameter int MINLEN = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sop,
  input logic          in_eop,
  input logic          take,
  input logic          in_pkt,
  input logic          out_valid,
  input logic          out_eop,
  input logic [EW-1:0] out_empty,
  input logic          sts_valid,
  input logic [LW-1:0] sts_len,
  input logic [3:0]    sts_flags
);
  // R3
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R4
  solo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sop && in_eop) |=> !out_valid);
  // R5
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |-> (out_empty == '0));
  // R9
  trunc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sop && in_pkt) |=> (sts_valid && sts_flags[1]));
  // R10
  orphan_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_sop && !in_pkt) |=> (!out_valid && !sts_valid));
  // R11
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_flags[1]) |-> (int'(sts_len) >= MINLEN));
endmodule

bind tx_ingress_check tx_ingress_check_sva #(
  .LW(LW), .EW(EW), .MINLEN(2 * (DW / 8) - (2 ** EW - 1))
) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
  .in_eop(in_eop), .take(take), .in_pkt(in_pkt), .out_valid(out_valid),
  .out_eop(out_eop), .out_empty(out_empty), .sts_valid(sts_valid),
  .sts_len(sts_len), .sts_flags(sts_flags)
);

// File: tb/sim_tx_ingress_check.sv
`timescale 1ns/1ps
module sim_tx_ingress_check;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ds_ready = 0, in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0;
  logic [3:0] in_empty = 0;
  logic [7:0] in_pre_tag = 8'hFB;
  logic [127:0] in_data = '0;
  logic rdy0, ov0, os0, oe0, sv0, rdy1, ov1, os1, oe1, sv1;
  logic [3:0] oem0, fl0, oem1, fl1;
  logic [127:0] od0, od1;
  logic [15:0] len0, len1;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tx_ingress_check u0 (.clk(clk), .rst_n(rst_n), .ds_ready(ds_ready), .in_ready(rdy0),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_err(in_err), .in_pre_tag(in_pre_tag), .in_data(in_data), .out_valid(ov0),
    .out_sop(os0), .out_eop(oe0), .out_empty(oem0), .out_data(od0),
    .sts_valid(sv0), .sts_len(len0), .sts_flags(fl0));

  tx_ingress_check #(.READY_LAT(3)) u1 (.clk(clk), .rst_n(rst_n), .ds_ready(ds_ready),
    .in_ready(rdy1), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .in_err(in_err), .in_pre_tag(in_pre_tag), .in_data(in_data),
    .out_valid(ov1), .out_sop(os1), .out_eop(oe1), .out_empty(oem1), .out_data(od1),
    .sts_valid(sv1), .sts_len(len1), .sts_flags(fl1));

  // bench model state and expectations
  bit m_in, m_pre, m_orph;
  int m_len;
  bit e_ov, e_sop, e_eop, e_sv;
  logic [3:0] e_emp, e_fl;
  logic [127:0] e_data;
  logic [15:0] e_len;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(bit v, bit s, bit e, logic [3:0] emp, bit er, logic [7:0] pm, bit r, logic [127:0] d);
    e_ov = 0; e_sv = 0; e_sop = 0; e_eop = 0; e_emp = 0; e_data = d;
    if (!(v && r)) return;
    if (s) begin
      if (m_in) begin
        e_sv = 1; e_len = 16'(m_len); e_fl = {1'b0, m_pre, 1'b1, m_orph}; m_orph = 0;
      end
      if (e) m_in = 0;
      else begin
        m_in = 1; m_len = 16; m_pre = (pm != 8'hFB); e_ov = 1; e_sop = 1;
      end
    end else if (m_in) begin
      e_ov = 1; e_eop = e; e_emp = e ? emp : 4'd0; m_len += 16;
      if (e) begin
        e_sv = 1; e_len = 16'(m_len - int'(emp)); e_fl = {er, m_pre, 1'b0, m_orph};
        m_orph = 0; m_in = 0;
      end
    end else m_orph = 1;
  endfunction

  task automatic cyc(bit v, bit s, bit e, logic [3:0] emp, bit er, logic [7:0] pm, bit r);
    logic [127:0] d;
    d = {$urandom, $urandom, $urandom, $urandom};
    in_valid = v; in_sop = s; in_eop = e; in_empty = emp; in_err = er;
    in_pre_tag = pm; ds_ready = r; in_data = d;
    model(v, s, e, emp, er, pm, r, d);
    @(negedge clk);
    chk(rdy0 == r, "R1 ready", rdy0, r);
    chk(ov0 == e_ov, "R3 out_valid", ov0, e_ov);
    if (e_ov) begin
      chk(od0 == e_data, "R3 data", od0, e_data);
      chk(os0 == e_sop && oe0 == e_eop, "R3 sop/eop", {os0, oe0}, {e_sop, e_eop});
      chk(oem0 == e_emp, "R5 empty", oem0, e_emp);
    end
    chk(sv0 == e_sv, "R6 sts_valid", sv0, e_sv);
    if (e_sv) begin
      chk(len0 == e_len, "R6 length", len0, e_len);
      chk(fl0 == e_fl, "R7 flags", fl0, e_fl);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 8'hFB, 1);
  endtask

  task automatic lat3_cyc(bit v, bit s, bit e, logic [3:0] emp, bit r);
    in_valid = v; in_sop = s; in_eop = e; in_empty = emp; in_err = 0;
    in_pre_tag = 8'hFB; ds_ready = r;
    @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(ov0 == 0 && sv0 == 0 && fl0 == 0 && len0 == 0, "R3 reset state", {ov0, sv0, fl0, len0}, 0);
    rst_n = 1;
    // 2-beat packet, empty 15 -> 17 bytes
    cyc(1, 1, 0, 0, 0, 8'hFB, 1); cyc(1, 0, 1, 15, 0, 8'hFB, 1);
    chk(sv0 && len0 == 17 && fl0 == 0, "R11 min length 17", len0, 17);
    // solo sop+eop dropped
    cyc(1, 1, 1, 3, 0, 8'hFB, 1);
    chk(!ov0 && !sv0, "R4 solo drop", {ov0, sv0}, 0);
    // valid without ready ignored
    cyc(1, 1, 0, 0, 0, 8'hFB, 0);
    chk(!ov0, "R1 no ready no take", ov0, 0);
    // orphan then packet with bad preamble and user error
    cyc(1, 0, 0, 0, 0, 8'hFB, 1);
    chk(!ov0, "R10 orphan dropped", ov0, 0);
    cyc(1, 1, 0, 0, 0, 8'h55, 1); cyc(1, 0, 0, 7, 0, 8'hFB, 1);
    chk(oem0 == 0, "R5 empty ignored mid packet", oem0, 0);
    cyc(1, 0, 1, 4, 1, 8'hFB, 1);
    chk(len0 == 44 && fl0 == 4'b1101, "R8 R10 R7 flags", {len0, fl0}, {16'd44, 4'b1101});
    // truncation
    cyc(1, 1, 0, 0, 0, 8'hFB, 1); cyc(1, 0, 0, 0, 0, 8'hFB, 1); cyc(1, 1, 0, 0, 0, 8'hFB, 1);
    chk(sv0 && fl0 == 4'b0010 && len0 == 32 && ov0 && os0, "R9 truncation", {len0, fl0}, {16'd32, 4'b0010});
    cyc(1, 0, 1, 0, 0, 8'hFB, 1);
    chk(sv0 && len0 == 32 && fl0 == 0, "R9 new packet closes", len0, 32);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, s, e, er, r; logic [7:0] pm;
      v = ($urandom % 4) != 0; r = ($urandom % 5) != 0;
      s = ($urandom % 7) == 0; e = ($urandom % 5) == 0; er = ($urandom % 6) == 0;
      pm = (($urandom % 5) == 0) ? 8'($urandom) : 8'hFB;
      cyc(v, s, e, 4'($urandom), er, pm, r);
    end
    idle();
    // latency 3 on u1
    rst_n = 0; lat3_cyc(0, 0, 0, 0, 0); lat3_cyc(0, 0, 0, 0, 0); rst_n = 1;
    lat3_cyc(0, 0, 0, 0, 1); lat3_cyc(0, 0, 0, 0, 0); lat3_cyc(0, 0, 0, 0, 0);
    lat3_cyc(1, 1, 0, 0, 0);
    chk(ov1 && os1, "R2 taken 3 after ready", {ov1, os1}, 2'b11);
    lat3_cyc(1, 0, 1, 2, 0);
    chk(!ov1, "R2 ignored without ready 3 earlier", ov1, 0);
    lat3_cyc(0, 0, 0, 0, 1); lat3_cyc(0, 0, 0, 0, 1); lat3_cyc(1, 0, 0, 0, 0);
    chk(!ov1, "R2 valid 2 after ready ignored", ov1, 0);
    lat3_cyc(1, 0, 1, 2, 0);
    chk(ov1 && oe1 && sv1 && len1 == 30, "R2 end taken, R6 length", {ov1, len1}, {1'b1, 16'd30});
    lat3_cyc(0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule